// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Controller

This block is the control core of a shared last-level cache. An upstream arbiter sends single-word read and write requests. Each request carries a 32-bit byte address and a small transaction id. The controller looks the address up in one tag bank per way. A hit is served from a local word-wide data store, and the answer comes back one cycle after the request is accepted. A miss starts a line replacement. If the chosen victim line is dirty, it is first streamed out to memory. The new line is then fetched over a 64-bit memory port, and the tag is installed. A write miss allocates the line and merges the write word into it as the line arrives.

Only one memory miss is in flight at a time. While it is pending, the controller keeps accepting requests that hit in any set other than the one being replaced. Because of this, responses can return out of order, and the id field tells the arbiter which request a response belongs to. The victim way is taken from an external replacement input, so any replacement policy can sit outside the block. The line size is a parameter of 32 or 64 bytes, which gives 4 or 8 memory beats per line.

Top module: `llc_wb_ctrl`

## Requirements
- R1: Reset leaves every line invalid and clean. The first access to any address after reset is a miss. req_ready is 1 and resp_valid, mem_wr_valid and mem_rd_req_valid are 0 until a request arrives.
- R2: A read that hits is answered with resp_valid in the cycle after acceptance. The response carries the stored word and the request's id.
- R3: A write that hits updates the addressed word, marks the line dirty and is acknowledged the next cycle. It causes no memory traffic.
- R4: Evicting a dirty line first sends LINE_BYTES/8 write beats of 64 bits to the victim line's addresses. Each beat carries its own byte address, ascending by 8. The lower-addressed word sits in bits 31:0, and mem_wr_last marks the final beat. No fill request is raised until the last beat is taken.
- R5: Evicting a clean or invalid line produces no write beats.
- R6: A miss issues one line-aligned read request, then accepts LINE_BYTES/8 beats in ascending address order. A read miss returns the requested word once the line is installed.
- R7: A write miss fetches the line, merges the write word into it and installs the line as dirty. Later reads see the merged word, and the other words keep their memory values.
- R8: The victim way is the value on repl_way in the cycle the miss is accepted.
- R9: While a refill is pending, a request that hits in a different set is accepted and answered one cycle later, ahead of the pending miss's response.
- R10: While a refill is pending, a request that misses is held with req_ready low. It is accepted no earlier than the cycle in which the pending miss responds.
- R11: While a refill is pending, a request to the set being replaced is held even if it would hit. It is accepted no earlier than the pending miss's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_id | input | ID_W | Transaction id echoed in the response |
| repl_way | input | WAY_W | Victim way used if this request misses |
| resp_valid | output | 1 | Response present for one cycle |
| resp_id | output | ID_W | Id of the answered request |
| resp_rdata | output | 32 | Read data (zero for writes) |
| mem_wr_valid | output | 1 | Write-back beat present |
| mem_wr_ready | input | 1 | Memory takes the write beat |
| mem_wr_addr | output | 32 | Byte address of the write beat |
| mem_wr_data | output | 64 | Write-back beat data |
| mem_wr_last | output | 1 | Final beat of the line |
| mem_rd_req_valid | output | 1 | Line fill request present |
| mem_rd_req_ready | input | 1 | Memory takes the fill request |
| mem_rd_addr | output | 32 | Line-aligned fill address |
| mem_rd_valid | input | 1 | Fill beat present |
| mem_rd_data | input | 64 | Fill beat data |

## Verification
The bench replays a sequence of accesses against a shadow memory, so that evictions drive lines out and bring them back. This exposes a dirty bit that was lost: the written value would vanish after the line is refetched, and the bench would see the stale memory word. Last-word write misses test the merge. A wrong beat-to-word mapping would show up as corrupted neighbours. The hit-under-miss tests slow the memory down and then time the acceptance of a hit to another set, a second miss, and a hit to the set being replaced. A controller that blocked on every miss would answer the hit late. One that let the second miss or the conflicting hit through would raise two fills at once, or read a half-written line.

// File: rtl/llc_pkg.sv
package llc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int MEM_W  = 64;

    // Miss sequencer states; order follows the eviction sequence
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_EVICT,
        MS_FILL_REQ,
        MS_FILL_DATA,
        MS_FINISH
    } miss_state_e;

    // Request captured for the outstanding miss
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } miss_req_t;

    function automatic logic [ADDR_W-1:0] align_line(input logic [ADDR_W-1:0] a,
                                                     input int off_w);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << off_w) - ADDR_W'(1);
        return a & ~mask;
    endfunction

endpackage

// File: rtl/llc_tag_bank.sv
module llc_tag_bank #(
    parameter int SETS  = 16,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);

    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
            end
            if (mark_en) dirty_q[mark_idx] <= 1'b1;
        end
    end

    assign rd_tag   = tags[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

endmodule

// File: rtl/llc_data_store.sv
module llc_data_store #(
    parameter int WAY_W = 1,
    parameter int IDX_W = 4,
    parameter int WRD_W = 3,
    localparam int BEAT_W = WRD_W - 1,
    localparam int AW     = WAY_W + IDX_W + WRD_W,
    localparam int DEPTH  = 1 << AW
) (
    input  logic              clk,
    // word port: hit access and miss completion
    input  logic [WAY_W-1:0]  a_way,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [WRD_W-1:0]  a_word,
    input  logic              a_we,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    // beat port: write-back read and fill write
    input  logic [WAY_W-1:0]  b_way,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [BEAT_W-1:0] b_beat,
    input  logic              b_we,
    input  logic [63:0]       b_wdata,
    output logic [63:0]       b_rdata
);

    logic [31:0] words [DEPTH];

    logic [AW-1:0] a_ptr, b_lo, b_hi;
    assign a_ptr = {a_way, a_idx, a_word};
    assign b_lo  = {b_way, b_idx, b_beat, 1'b0};
    assign b_hi  = {b_way, b_idx, b_beat, 1'b1};

    always_ff @(posedge clk) begin
        if (a_we) words[a_ptr] <= a_wdata;
        if (b_we) begin
            words[b_lo] <= b_wdata[31:0];
            words[b_hi] <= b_wdata[63:32];
        end
    end

    assign a_rdata = words[a_ptr];
    assign b_rdata = {words[b_hi], words[b_lo]};

endmodule

// File: rtl/llc_wb_ctrl.sv
module llc_wb_ctrl
    import llc_pkg::*;
#(
    parameter int NUM_WAYS   = 2,
    parameter int NUM_SETS   = 16,
    parameter int LINE_BYTES = 32,
    parameter int ID_W       = 4,
    localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(NUM_SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int WPL    = LINE_BYTES / 4,
    localparam int WRD_W  = $clog2(WPL),
    localparam int BEATS  = LINE_BYTES / 8,
    localparam int BEAT_W = WRD_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [ID_W-1:0]   req_id,
    input  logic [WAY_W-1:0]  repl_way,
    output logic              resp_valid,
    output logic [ID_W-1:0]   resp_id,
    output logic [31:0]       resp_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [31:0]       mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic              mem_wr_last,
    output logic              mem_rd_req_valid,
    input  logic              mem_rd_req_ready,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data
);

    // ---------------- request address decode ----------------
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [WRD_W-1:0] req_word;
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_word = req_addr[2 +: WRD_W];

    // ---------------- miss context ----------------
    miss_state_e       state;
    miss_req_t         m_req;
    logic [ID_W-1:0]   m_id;
    logic [WAY_W-1:0]  m_way;
    logic [TAG_W-1:0]  m_vtag;
    logic [BEAT_W-1:0] beat;

    logic [TAG_W-1:0] m_tag;
    logic [IDX_W-1:0] m_idx;
    logic [WRD_W-1:0] m_word;
    assign m_tag  = m_req.addr[ADDR_W-1 -: TAG_W];
    assign m_idx  = m_req.addr[OFF_W +: IDX_W];
    assign m_word = m_req.addr[2 +: WRD_W];

    logic finishing, last_beat;
    assign finishing = (state == MS_FINISH);
    assign last_beat = (beat == BEAT_W'(BEATS - 1));

    // ---------------- tag banks, one per way ----------------
    logic [TAG_W-1:0]    way_tag [NUM_WAYS];
    logic [NUM_WAYS-1:0] way_valid, way_dirty, hit_vec;
    logic                hit, hit_acc, miss_acc, accept;
    logic [WAY_W-1:0]    hit_way;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        llc_tag_bank #(.SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
            .clk        (clk),
            .rst        (rst),
            .rd_idx     (req_idx),
            .rd_tag     (way_tag[w]),
            .rd_valid   (way_valid[w]),
            .rd_dirty   (way_dirty[w]),
            .fill_en    (finishing && (m_way == WAY_W'(w))),
            .fill_idx   (m_idx),
            .fill_tag   (m_tag),
            .fill_dirty (m_req.wr),
            .mark_en    (hit_acc && req_write && (hit_way == WAY_W'(w))),
            .mark_idx   (req_idx)
        );
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    assign hit = |hit_vec;

    // out-of-range replacement choices fall back to way 0
    logic [WAY_W-1:0] vic_way;
    logic             vic_dirty;
    assign vic_way   = ({1'b0, repl_way} < (WAY_W+1)'(NUM_WAYS)) ? repl_way : '0;
    assign vic_dirty = way_valid[vic_way] && way_dirty[vic_way];

    // ---------------- acceptance ----------------
    logic busy, same_set;
    assign busy      = (state != MS_IDLE);
    assign same_set  = busy && (req_idx == m_idx);
    assign req_ready = !busy || (!finishing && hit && !same_set);
    assign accept    = req_valid && req_ready;
    assign hit_acc   = accept && hit;
    assign miss_acc  = accept && !hit;

    // ---------------- data store ----------------
    logic [31:0] a_rdata;
    logic [63:0] b_rdata, fill_merged;

    always_comb begin
        fill_merged = mem_rd_data;
        if (m_req.wr && (m_word[WRD_W-1:1] == beat)) begin
            if (m_word[0]) fill_merged[63:32] = m_req.wdata;
            else           fill_merged[31:0]  = m_req.wdata;
        end
    end

    llc_data_store #(.WAY_W(WAY_W), .IDX_W(IDX_W), .WRD_W(WRD_W)) u_data (
        .clk     (clk),
        .a_way   (finishing ? m_way  : hit_way),
        .a_idx   (finishing ? m_idx  : req_idx),
        .a_word  (finishing ? m_word : req_word),
        .a_we    (hit_acc && req_write),
        .a_wdata (req_wdata),
        .a_rdata (a_rdata),
        .b_way   (m_way),
        .b_idx   (m_idx),
        .b_beat  (beat),
        .b_we    ((state == MS_FILL_DATA) && mem_rd_valid),
        .b_wdata (fill_merged),
        .b_rdata (b_rdata)
    );

    // ---------------- memory side ----------------
    assign mem_wr_valid     = (state == MS_EVICT);
    assign mem_wr_addr      = {m_vtag, m_idx, OFF_W'(0)} + {beat, 3'b000};
    assign mem_wr_data      = b_rdata;
    assign mem_wr_last      = mem_wr_valid && last_beat;
    assign mem_rd_req_valid = (state == MS_FILL_REQ);
    assign mem_rd_addr      = align_line(m_req.addr, OFF_W);

    // ---------------- sequencer and response ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= MS_IDLE;
            beat       <= '0;
            resp_valid <= 1'b0;
            resp_id    <= '0;
            resp_rdata <= '0;
            m_req      <= '0;
            m_id       <= '0;
            m_way      <= '0;
            m_vtag     <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (hit_acc) begin
                resp_valid <= 1'b1;
                resp_id    <= req_id;
                resp_rdata <= req_write ? 32'd0 : a_rdata;
            end
            unique case (state)
                MS_IDLE: if (miss_acc) begin
                    m_req  <= '{wr: req_write, addr: req_addr, wdata: req_wdata};
                    m_id   <= req_id;
                    m_way  <= vic_way;
                    m_vtag <= way_tag[vic_way];
                    beat   <= '0;
                    state  <= vic_dirty ? MS_EVICT : MS_FILL_REQ;
                end
                MS_EVICT: if (mem_wr_ready) begin
                    beat <= last_beat ? '0 : beat + 1'b1;
                    if (last_beat) state <= MS_FILL_REQ;
                end
                MS_FILL_REQ: if (mem_rd_req_ready) state <= MS_FILL_DATA;
                MS_FILL_DATA: if (mem_rd_valid) begin
                    beat <= last_beat ? '0 : beat + 1'b1;
                    if (last_beat) state <= MS_FINISH;
                end
                MS_FINISH: begin
                    resp_valid <= 1'b1;
                    resp_id    <= m_id;
                    resp_rdata <= m_req.wr ? 32'd0 : a_rdata;
                    state      <= MS_IDLE;
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/llc_wb_ctrl_checker.sv
module llc_wb_ctrl_checker #(
    parameter int BEATS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        resp_valid,
    input logic        mem_wr_valid,
    input logic        mem_wr_ready,
    input logic [31:0] mem_wr_addr,
    input logic [63:0] mem_wr_data,
    input logic        mem_wr_last,
    input logic        mem_rd_req_valid,
    input logic        mem_rd_req_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid
);

    logic [7:0] wr_cnt, fill_cnt;
    logic       fill_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt    <= '0;
            fill_cnt  <= '0;
            fill_open <= 1'b0;
        end else begin
            if (mem_wr_valid && mem_wr_ready)
                wr_cnt <= mem_wr_last ? 8'd0 : wr_cnt + 8'd1;
            if (mem_rd_req_valid && mem_rd_req_ready) begin
                fill_open <= 1'b1;
                fill_cnt  <= '0;
            end else if (fill_open && mem_rd_valid) begin
                fill_cnt <= fill_cnt + 8'd1;
                if (fill_cnt == 8'(BEATS - 1)) fill_open <= 1'b0;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !resp_valid && !mem_wr_valid && !mem_rd_req_valid); // R1

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R4

    AST_WB_LAST_POS: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid && mem_wr_last |-> wr_cnt == 8'(BEATS - 1)); // R4

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_valid && mem_rd_req_valid)); // R4

    AST_FILL_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req_valid && !mem_rd_req_ready |=> mem_rd_req_valid && $stable(mem_rd_addr)); // R6

    AST_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req_valid |-> !fill_open); // R10

endmodule

bind llc_wb_ctrl llc_wb_ctrl_checker #(.BEATS(BEATS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .resp_valid       (resp_valid),
    .mem_wr_valid     (mem_wr_valid),
    .mem_wr_ready     (mem_wr_ready),
    .mem_wr_addr      (mem_wr_addr),
    .mem_wr_data      (mem_wr_data),
    .mem_wr_last      (mem_wr_last),
    .mem_rd_req_valid (mem_rd_req_valid),
    .mem_rd_req_ready (mem_rd_req_ready),
    .mem_rd_addr      (mem_rd_addr),
    .mem_rd_valid     (mem_rd_valid)
);

// File: tb/llc_wb_ctrl_tb_top.sv
`timescale 1ns/1ps
module llc_wb_ctrl_tb_top;

    localparam int BEATS = 4;   // 32-byte lines

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_id = '0;
    logic [0:0]  repl_way = '0;
    logic        resp_valid;
    logic [3:0]  resp_id;
    logic [31:0] resp_rdata;
    logic        mem_wr_valid, mem_wr_last;
    logic        mem_wr_ready = 1'b1;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        mem_rd_req_valid;
    logic        mem_rd_req_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;

    always #2 clk = ~clk;   // 250 MHz

    llc_wb_ctrl dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
        .repl_way(repl_way),
        .resp_valid(resp_valid), .resp_id(resp_id), .resp_rdata(resp_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_last(mem_wr_last),
        .mem_rd_req_valid(mem_rd_req_valid), .mem_rd_req_ready(mem_rd_req_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // ---------------- shadow models ----------------
    logic [31:0] ref_w [int unsigned];
    logic [31:0] mem_w [int unsigned];

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return ref_w.exists(a) ? ref_w[a] : init_word(a);
    endfunction
    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem_w.exists(a) ? mem_w[a] : init_word(a);
    endfunction

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // ---------------- response monitor ----------------
    bit          got  [16];
    logic [31:0] rdat [16];
    int          rcyc [16];
    initial forever begin
        @(negedge clk);
        if (resp_valid) begin
            got[resp_id]  = 1;
            rdat[resp_id] = resp_rdata;
            rcyc[resp_id] = cyc;
        end
    end

    // ---------------- memory model ----------------
    int wb_beats = 0, wb_in_line = 0, fill_lat = 2;
    bit pend = 0;
    int delay = 0, fbeat = 0;
    logic [31:0] faddr = '0;
    initial forever begin
        @(negedge clk);
        mem_rd_valid = 1'b0;
        if (mem_wr_valid && mem_wr_ready) begin
            check(mem_wr_data[31:0] == ref_rd(mem_wr_addr), "R4 write-back low word",
                  64'(mem_wr_data[31:0]), 64'(ref_rd(mem_wr_addr)));
            check(mem_wr_data[63:32] == ref_rd(mem_wr_addr + 4), "R4 write-back high word",
                  64'(mem_wr_data[63:32]), 64'(ref_rd(mem_wr_addr + 4)));
            check(mem_wr_last == (wb_in_line == BEATS - 1), "R4 last-beat flag",
                  64'(mem_wr_last), 64'(wb_in_line == BEATS - 1));
            mem_w[mem_wr_addr]     = mem_wr_data[31:0];
            mem_w[mem_wr_addr + 4] = mem_wr_data[63:32];
            wb_beats++;
            wb_in_line = (wb_in_line == BEATS - 1) ? 0 : wb_in_line + 1;
        end
        if (pend) begin
            if (delay > 0) delay--;
            else begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = {mem_rd(faddr + 32'(fbeat * 8) + 4), mem_rd(faddr + 32'(fbeat * 8))};
                fbeat++;
                if (fbeat == BEATS) pend = 0;
            end
        end else if (mem_rd_req_valid && mem_rd_req_ready) begin
            check(mem_rd_addr[4:0] == 5'd0, "R6 fill address line aligned",
                  64'(mem_rd_addr), 64'(mem_rd_addr & ~32'h1F));
            pend = 1; delay = fill_lat; fbeat = 0; faddr = mem_rd_addr;
        end
    end

    // ---------------- request driver ----------------
    task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input int id, input int way, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_id = 4'(id); repl_way = 1'(way); got[id] = 0;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) ref_w[a] = d;
    endtask

    task automatic wait_resp(input int id);
        while (!got[id]) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic        way;
        logic        hit;
        logic        wb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h1004, 32'h0,        1'b0, 1'b0, 1'b0}, // cold miss
        '{1'b0, 32'h1008, 32'h0,        1'b0, 1'b1, 1'b0}, // read hit
        '{1'b1, 32'h100C, 32'h11111111, 1'b0, 1'b1, 1'b0}, // write hit, dirty
        '{1'b0, 32'h100C, 32'h0,        1'b0, 1'b1, 1'b0},
        '{1'b0, 32'h1204, 32'h0,        1'b1, 1'b0, 1'b0}, // fill way 1
        '{1'b1, 32'h1400, 32'h22222222, 1'b0, 1'b0, 1'b1}, // write miss evicts dirty
        '{1'b0, 32'h1400, 32'h0,        1'b0, 1'b1, 1'b0},
        '{1'b0, 32'h100C, 32'h0,        1'b1, 1'b0, 1'b0}, // evict clean, refetch
        '{1'b0, 32'h1204, 32'h0,        1'b0, 1'b0, 1'b1}, // evict dirty merged line
        '{1'b0, 32'h1400, 32'h0,        1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h103C, 32'h33333333, 1'b0, 1'b0, 1'b0}, // merge into last word
        '{1'b0, 32'h103C, 32'h0,        1'b0, 1'b1, 1'b0},
        '{1'b0, 32'h1038, 32'h0,        1'b0, 1'b1, 1'b0},
        '{1'b0, 32'h1020, 32'h0,        1'b0, 1'b1, 1'b0}
    };

    initial begin
        int acc, a1, a2, a3, a4, a5, a6, wb0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: quiet outputs after reset
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(!resp_valid && !mem_wr_valid && !mem_rd_req_valid, "R1 outputs idle after reset",
              64'({resp_valid, mem_wr_valid, mem_rd_req_valid}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            wb0 = wb_beats;
            issue(TBL[i].wr, TBL[i].addr, TBL[i].data, i % 16, int'(TBL[i].way), acc);
            wait_resp(i % 16);
            if (TBL[i].hit)
                check(rcyc[i % 16] == acc + 1, TBL[i].wr ? "R3 write hit latency" : "R2 read hit latency",
                      64'(rcyc[i % 16] - acc), 64'd1);
            else
                check(rcyc[i % 16] > acc + 1, "R8 miss expected (R1 cold or R8 victim choice)",
                      64'(rcyc[i % 16] - acc), 64'd2);
            if (!TBL[i].wr)
                check(rdat[i % 16] == ref_rd(TBL[i].addr), TBL[i].hit ? "R2 read data" : "R6 R7 miss read data",
                      64'(rdat[i % 16]), 64'(ref_rd(TBL[i].addr)));
            check(wb_beats - wb0 == (TBL[i].wb ? BEATS : 0), TBL[i].wb ? "R4 dirty victim beats" : "R5 no write-back",
                  64'(wb_beats - wb0), 64'(TBL[i].wb ? BEATS : 0));
        end

        // R9: hit to another set while a slow refill is pending
        fill_lat = 25;
        issue(1'b0, 32'h1840, 32'h0, 1, 0, a1);
        issue(1'b0, 32'h1404, 32'h0, 2, 0, a2);
        wait_resp(2); wait_resp(1);
        check(rcyc[2] == a2 + 1, "R9 hit under miss latency", 64'(rcyc[2] - a2), 64'd1);
        check(rcyc[2] < rcyc[1], "R9 hit answered before pending miss", 64'(rcyc[2]), 64'(rcyc[1]));
        check(rdat[2] == ref_rd(32'h1404), "R9 hit under miss data", 64'(rdat[2]), 64'(ref_rd(32'h1404)));
        check(rdat[1] == ref_rd(32'h1840), "R6 slow fill data", 64'(rdat[1]), 64'(ref_rd(32'h1840)));

        // R10: a second miss waits for the first
        issue(1'b0, 32'h1860, 32'h0, 3, 0, a3);
        issue(1'b0, 32'h1880, 32'h0, 4, 0, a4);
        wait_resp(4);
        check(a4 >= rcyc[3], "R10 second miss held", 64'(a4), 64'(rcyc[3]));
        check(rdat[4] == ref_rd(32'h1880), "R10 second miss data", 64'(rdat[4]), 64'(ref_rd(32'h1880)));

        // R11: a hit to the set under replacement waits
        issue(1'b0, 32'h1A40, 32'h0, 5, 1, a5);
        issue(1'b0, 32'h1844, 32'h0, 6, 0, a6);
        wait_resp(6);
        check(a6 >= rcyc[5], "R11 same-set hit held", 64'(a6), 64'(rcyc[5]));
        check(rcyc[6] == a6 + 1, "R11 held request then hits", 64'(rcyc[6] - a6), 64'd1);
        check(rdat[6] == ref_rd(32'h1844), "R11 same-set data", 64'(rdat[6]), 64'(ref_rd(32'h1844)));

        // R1: reset in the middle invalidates a resident line
        fill_lat = 2;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        #1;
        check(req_ready && !resp_valid && !mem_wr_valid && !mem_rd_req_valid, "R1 idle after second reset",
              64'({req_ready, resp_valid, mem_wr_valid, mem_rd_req_valid}), 64'h8);
        issue(1'b0, 32'h1008, 32'h0, 7, 0, acc);
        wait_resp(7);
        check(rcyc[7] > acc + 1, "R1 resident line invalid after reset", 64'(rcyc[7] - acc), 64'd2);
        check(rdat[7] == ref_rd(32'h1008), "R1 data after reset", 64'(rdat[7]), 64'(ref_rd(32'h1008)));

        finish_up();
    end

    initial begin
        #(4 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule